// File: doc/BRIEF.md
# Multicore Hardware Semaphore Bank

This block holds a bank of independent lock flags that several processor cores share to keep exclusive use of common resources. Every core has its own access port: a request strobe, a write flag, an address that picks the access kind and the semaphore number, and write data. The port returns a ready flag and read data in the same cycle. The core that issues an access is the core that owns the port, so the requester ID comes from the port index.

A read of a semaphore's direct register is an atomic test-and-set. It either takes the semaphore for the reader or reports which core holds it. A read of the query register only reports the state. Writing the value 1 through either register lets the holder give the semaphore up. A control write clears the whole bank. Misuse is reported as a one-cycle strobe with a code on a separate error lane for each core. The block raises no grant notification. Which semaphore guards which resource is left to software.

Top module: `hwsem_bank`

## Requirements
- R1: Each port address is {kind[1:0], sem[5:0]}. The kind is 00 for direct, 01 for query, 10 for control and 11 for reserved. A reserved read returns 0, and a reserved write changes no semaphore and raises no error.
- R2: A direct read of a free semaphore returns 0x1 in the same cycle, and the reading core holds the semaphore from the next cycle on.
- R3: A direct read of a semaphore held by another core returns {holder_id, 1'b0}, so bit 0 is 0. The holder does not change.
- R4: A query read never changes any semaphore. It returns 0x1 when the semaphore is free and {holder_id, 1'b0} when it is held.
- R5: A write of exactly 0x1 by the holder, through the direct kind or the query kind, frees the semaphore. Write data other than 0x1 is ignored and raises no error.
- R6: A write of 0x1 by a core that is not the holder leaves the semaphore held and reports code 1 (illegal free). A write of 0x1 to a free semaphore reports code 0 (already free).
- R7: A direct read by the core that already holds the semaphore returns {holder_id, 1'b0}, keeps the semaphore held and reports code 2 (already own).
- R8: An error makes err_valid[c] high for exactly the one cycle that follows the access. In that cycle err_code[c] and err_sem[c] carry the code and the semaphore number. The lane index c is the ID of the offending core.
- R9: After a hardware reset every semaphore is free. A control write with wdata bit 0 set also frees every semaphore. In a cycle that has a control access, that access is served and every non-control access of the other cores is held off with ready low.
- R10: When several cores access the same semaphore in one cycle, only the lowest-numbered core is served and the others see ready low. Accesses to different semaphores in the same cycle are all served.
- R11: A successful acquire raises no error strobe, and the block has no grant notification output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req | input | NUM_CORES | Access request, one bit per core |
| wr | input | NUM_CORES | 1 = write, 0 = read, one bit per core |
| addr | input | NUM_CORES*(SEM_W+2) | Kind and semaphore number for each core |
| wdata | input | NUM_CORES*DATA_W | Write data for each core |
| ready | output | NUM_CORES | High when the core's access is served this cycle, or when the core has no request |
| rdata | output | NUM_CORES*DATA_W | Read result for each core, valid while req and ready are both high |
| err_valid | output | NUM_CORES | One-cycle error strobe for each core |
| err_code | output | NUM_CORES*2 | Error code: 0 already free, 1 illegal free, 2 already own |
| err_sem | output | NUM_CORES*SEM_W | Semaphore number of the reported error |

## Verification
The bench builds the bank with its default parameters: 64 semaphores, 4 cores and 32-bit data. With these values the lowest and highest semaphore numbers can be reached, and so can every core ID as a holder. Holder ID 3, which comes back as 0x6, exercises the full width of the ID field. Four ports allow two cores to collide on one semaphore while two others work on distinct ones in the same cycle. They also allow a soft reset to arrive in the same cycle as a competing acquire.

// File: rtl/hwsem_pkg.sv
package hwsem_pkg;

  typedef enum logic [1:0] {
    KIND_DIRECT = 2'b00,
    KIND_QUERY  = 2'b01,
    KIND_CTRL   = 2'b10,
    KIND_RSVD   = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    ERR_ALREADY_FREE = 2'd0,
    ERR_ILLEGAL_FREE = 2'd1,
    ERR_ALREADY_OWN  = 2'd2
  } err_code_e;

endpackage

// File: rtl/hwsem_arbiter.sv
module hwsem_arbiter #(
  parameter int NUM_CORES = 4,
  parameter int SEM_W     = 6
) (
  input  logic [NUM_CORES-1:0]       req,
  input  logic [NUM_CORES-1:0]       is_ctrl,
  input  logic [NUM_CORES*SEM_W-1:0] sem_idx,
  output logic [NUM_CORES-1:0]       served,
  output logic [NUM_CORES-1:0]       ready
);

  logic                 ctrl_any;
  logic [NUM_CORES-1:0] blocked;

  // A control access takes the whole cycle. Otherwise the lowest core wins
  // among accesses that target the same semaphore.
  always_comb begin
    ctrl_any = |(req & is_ctrl);
    blocked  = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int j = 0; j < NUM_CORES; j++) begin
        if (j < c && req[j] && !is_ctrl[j] &&
            sem_idx[j*SEM_W +: SEM_W] == sem_idx[c*SEM_W +: SEM_W]) begin
          blocked[c] = 1'b1;
        end
      end
    end
    for (int c = 0; c < NUM_CORES; c++) begin
      served[c] = req[c] && (is_ctrl[c] || (!ctrl_any && !blocked[c]));
    end
    ready = ~req | served;
  end

endmodule

// File: rtl/hwsem_port.sv
module hwsem_port
  import hwsem_pkg::*;
#(
  parameter int CORE_ID = 0,
  parameter int CID_W   = 2,
  parameter int DATA_W  = 32
) (
  input  logic              served,
  input  logic              wr,
  input  logic [1:0]        kind,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cur_busy,
  input  logic [CID_W-1:0]  cur_owner,
  output logic [DATA_W-1:0] rdata,
  output logic              do_acq,
  output logic              do_rel,
  output logic              do_srst,
  output logic              err_hit,
  output logic [1:0]        err_code
);

  logic              is_mine;
  logic              rel_cmd;
  logic [DATA_W-1:0] holder_word;
  logic [DATA_W-1:0] state_word;

  always_comb begin
    is_mine     = cur_busy && (cur_owner == CID_W'(CORE_ID));
    rel_cmd     = wr && (wdata == DATA_W'(1));
    holder_word = DATA_W'({cur_owner, 1'b0});
    state_word  = cur_busy ? holder_word : DATA_W'(1);

    rdata    = '0;
    do_acq   = 1'b0;
    do_rel   = 1'b0;
    do_srst  = 1'b0;
    err_hit  = 1'b0;
    err_code = ERR_ALREADY_FREE;

    if (served) begin
      unique case (kind)
        KIND_DIRECT, KIND_QUERY: begin
          if (!wr) begin
            rdata = state_word;
            if (kind == KIND_DIRECT) begin
              if (!cur_busy) begin
                do_acq = 1'b1;
              end else if (is_mine) begin
                err_hit  = 1'b1;
                err_code = ERR_ALREADY_OWN;
              end
            end
          end else if (rel_cmd) begin
            if (!cur_busy) begin
              err_hit  = 1'b1;
              err_code = ERR_ALREADY_FREE;
            end else if (is_mine) begin
              do_rel = 1'b1;
            end else begin
              err_hit  = 1'b1;
              err_code = ERR_ILLEGAL_FREE;
            end
          end
        end
        KIND_CTRL: begin
          do_srst = wr && wdata[0];
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/hwsem_slot.sv
module hwsem_slot #(
  parameter int NUM_CORES = 4,
  parameter int CID_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] acq,
  input  logic [NUM_CORES-1:0] rel,
  input  logic                 srst,
  output logic                 busy,
  output logic [CID_W-1:0]     owner
);

  logic             busy_q, busy_d;
  logic [CID_W-1:0] owner_q, owner_d;
  logic             upd_en;

  always_comb begin
    busy_d  = busy_q;
    owner_d = owner_q;
    upd_en  = srst || (|acq) || (|rel);
    if (srst) begin
      busy_d  = 1'b0;
      owner_d = '0;
    end else if (|acq) begin
      busy_d = 1'b1;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (acq[c]) owner_d = CID_W'(c);
      end
    end else if (|rel) begin
      busy_d  = 1'b0;
      owner_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (upd_en) begin
      busy_q  <= busy_d;
      owner_q <= owner_d;
    end
  end

  assign busy  = busy_q;
  assign owner = owner_q;

  // R10: the arbiter lets at most one core acquire a given semaphore
  a_r10_single_acquirer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acq));
  // R2: an acquire leaves the semaphore held
  a_r2_acquire_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && acq != '0) |=> busy_q);
  // R5: a release is only issued for a held semaphore and frees it
  a_r5_release_needs_holder: assert property (@(posedge clk) disable iff (!rst_n)
    (rel != '0) |-> busy_q);
  a_r5_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && acq == '0 && rel != '0) |=> !busy_q);
  // R9: soft reset frees the semaphore
  a_r9_soft_reset_frees: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !busy_q);
  // R4: with no update the state holds
  a_r4_state_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && acq == '0 && rel == '0) |=> ($stable(busy_q) && $stable(owner_q)));

endmodule

// File: rtl/hwsem_bank.sv
module hwsem_bank
  import hwsem_pkg::*;
#(
  parameter int NUM_SEM   = 64,
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  localparam int SEM_W    = $clog2(NUM_SEM),
  localparam int CID_W    = $clog2(NUM_CORES),
  localparam int ADDR_W   = SEM_W + 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES-1:0]        req,
  input  logic [NUM_CORES-1:0]        wr,
  input  logic [NUM_CORES*ADDR_W-1:0] addr,
  input  logic [NUM_CORES*DATA_W-1:0] wdata,
  output logic [NUM_CORES-1:0]        ready,
  output logic [NUM_CORES*DATA_W-1:0] rdata,
  output logic [NUM_CORES-1:0]        err_valid,
  output logic [NUM_CORES*2-1:0]      err_code,
  output logic [NUM_CORES*SEM_W-1:0]  err_sem
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // per-core address decode
  logic [NUM_CORES-1:0]       is_ctrl;
  logic [NUM_CORES*SEM_W-1:0] sem_flat;
  logic [1:0]                 kind_c [NUM_CORES];

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      kind_c[c]                    = addr[c*ADDR_W + SEM_W +: 2];
      sem_flat[c*SEM_W +: SEM_W]   = addr[c*ADDR_W +: SEM_W];
      is_ctrl[c]                   = (kind_c[c] == KIND_CTRL);
    end
  end

  logic [NUM_CORES-1:0] served;

  hwsem_arbiter #(
    .NUM_CORES (NUM_CORES),
    .SEM_W     (SEM_W)
  ) u_arb (
    .req     (req),
    .is_ctrl (is_ctrl),
    .sem_idx (sem_flat),
    .served  (served),
    .ready   (ready)
  );

  // semaphore state
  logic             busy_v  [NUM_SEM];
  logic [CID_W-1:0] owner_v [NUM_SEM];

  logic [NUM_CORES-1:0] acq_c, rel_c, srst_c, err_hit_c;
  logic [1:0]           code_c [NUM_CORES];
  logic                 srst_any;

  assign srst_any = |srst_c;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_port
    hwsem_port #(
      .CORE_ID (c),
      .CID_W   (CID_W),
      .DATA_W  (DATA_W)
    ) u_port (
      .served    (served[c]),
      .wr        (wr[c]),
      .kind      (kind_c[c]),
      .wdata     (wdata[c*DATA_W +: DATA_W]),
      .cur_busy  (busy_v[sem_flat[c*SEM_W +: SEM_W]]),
      .cur_owner (owner_v[sem_flat[c*SEM_W +: SEM_W]]),
      .rdata     (rdata[c*DATA_W +: DATA_W]),
      .do_acq    (acq_c[c]),
      .do_rel    (rel_c[c]),
      .do_srst   (srst_c[c]),
      .err_hit   (err_hit_c[c]),
      .err_code  (code_c[c])
    );

    // R11: a grant never produces an error strobe on the granted core
    a_r11_grant_silent: assert property (@(posedge clk) disable iff (!rst_i)
      acq_c[c] |=> !err_valid[c]);
  end

  for (genvar s = 0; s < NUM_SEM; s++) begin : g_slot
    logic [NUM_CORES-1:0] acq_s, rel_s;

    always_comb begin
      for (int c = 0; c < NUM_CORES; c++) begin
        acq_s[c] = acq_c[c] && (sem_flat[c*SEM_W +: SEM_W] == SEM_W'(s));
        rel_s[c] = rel_c[c] && (sem_flat[c*SEM_W +: SEM_W] == SEM_W'(s));
      end
    end

    hwsem_slot #(
      .NUM_CORES (NUM_CORES),
      .CID_W     (CID_W)
    ) u_slot (
      .clk   (clk),
      .rst_n (rst_i),
      .acq   (acq_s),
      .rel   (rel_s),
      .srst  (srst_any),
      .busy  (busy_v[s]),
      .owner (owner_v[s])
    );
  end

  // error lanes, one registered strobe per core
  logic [NUM_CORES-1:0]       ev_q;
  logic [NUM_CORES*2-1:0]     code_q;
  logic [NUM_CORES*SEM_W-1:0] esem_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ev_q   <= '0;
      code_q <= '0;
      esem_q <= '0;
    end else begin
      ev_q <= err_hit_c;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (err_hit_c[c]) begin
          code_q[c*2 +: 2]     <= code_c[c];
          esem_q[c*SEM_W +: SEM_W] <= sem_flat[c*SEM_W +: SEM_W];
        end
      end
    end
  end

  assign err_valid = ev_q;
  assign err_code  = code_q;
  assign err_sem   = esem_q;

  // R9: a served control access excludes every served semaphore access
  a_r9_ctrl_exclusive: assert property (@(posedge clk) disable iff (!rst_i)
    (|(served & is_ctrl)) |-> ((served & ~is_ctrl) == '0));
  // R10: a core without a request always sees ready
  a_r10_idle_ready: assert property (@(posedge clk) disable iff (!rst_i)
    ((~req & ~ready) == '0));

endmodule

// File: tb/hwsem_bank_test.sv
module hwsem_bank_test;
  import hwsem_pkg::*;

  localparam int NC = 4;
  localparam int NS = 64;
  localparam int DW = 32;
  localparam int SW = 6;
  localparam int AW = SW + 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic [NC-1:0]    req, wr;
  logic [NC*AW-1:0] addr;
  logic [NC*DW-1:0] wdata;
  logic [NC-1:0]    ready;
  logic [NC*DW-1:0] rdata;
  logic [NC-1:0]    err_valid;
  logic [NC*2-1:0]  err_code;
  logic [NC*SW-1:0] err_sem;

  hwsem_bank uut (
    .clk (clk), .rst_n (rst_n), .req (req), .wr (wr), .addr (addr),
    .wdata (wdata), .ready (ready), .rdata (rdata), .err_valid (err_valid),
    .err_code (err_code), .err_sem (err_sem)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    req = '0; wr = '0; addr = '0; wdata = '0;
  endtask

  task automatic drive(input int c, input bit w, input logic [1:0] k,
                       input int s, input logic [31:0] d);
    req[c] = 1'b1;
    wr[c]  = w;
    addr[c*AW +: AW]  = {k, SW'(s)};
    wdata[c*DW +: DW] = d;
  endtask

  // one access by one core; results sampled mid-cycle, error lane one cycle later
  task automatic run1(input int c, input bit w, input logic [1:0] k, input int s,
                      input logic [31:0] d, output logic [31:0] rd, output logic rdy,
                      output logic ev, output logic [1:0] code, output logic [SW-1:0] es);
    @(negedge clk);
    idle_all();
    drive(c, w, k, s, d);
    #1;
    rdy = ready[c];
    rd  = rdata[c*DW +: DW];
    @(posedge clk);
    #1 idle_all();
    @(negedge clk);
    ev   = err_valid[c];
    code = err_code[c*2 +: 2];
    es   = err_sem[c*SW +: SW];
  endtask

  // vector: {req_tag, core, wr, kind, sem, wdata, exp_rdata, exp_ev, exp_code}
  localparam int VW = 34;
  localparam int NV = 21;
  localparam logic [VW-1:0] TBL [NV] = '{
    {4'd2, 2'd0, 1'b0, 2'd0, 6'd5,  8'd0, 8'h01, 1'b0, 2'd0}, // R2 free grant
    {4'd3, 2'd1, 1'b0, 2'd0, 6'd5,  8'd0, 8'h00, 1'b0, 2'd0}, // R3 refused, holder 0
    {4'd4, 2'd2, 1'b0, 2'd1, 6'd5,  8'd0, 8'h00, 1'b0, 2'd0}, // R4 query held
    {4'd7, 2'd0, 1'b0, 2'd0, 6'd5,  8'd0, 8'h00, 1'b1, 2'd2}, // R7 already own
    {4'd6, 2'd1, 1'b1, 2'd0, 6'd5,  8'd1, 8'h00, 1'b1, 2'd1}, // R6 illegal free
    {4'd4, 2'd3, 1'b0, 2'd1, 6'd5,  8'd0, 8'h00, 1'b0, 2'd0}, // R4 still held by 0
    {4'd5, 2'd0, 1'b1, 2'd1, 6'd5,  8'd2, 8'h00, 1'b0, 2'd0}, // R5 value 2 ignored
    {4'd4, 2'd1, 1'b0, 2'd1, 6'd5,  8'd0, 8'h00, 1'b0, 2'd0}, // R4 still held
    {4'd5, 2'd0, 1'b1, 2'd1, 6'd5,  8'd1, 8'h00, 1'b0, 2'd0}, // R5 release by holder
    {4'd4, 2'd1, 1'b0, 2'd1, 6'd5,  8'd0, 8'h01, 1'b0, 2'd0}, // R4 now free
    {4'd6, 2'd2, 1'b1, 2'd0, 6'd5,  8'd1, 8'h00, 1'b1, 2'd0}, // R6 already free
    {4'd2, 2'd3, 1'b0, 2'd0, 6'd63, 8'd0, 8'h01, 1'b0, 2'd0}, // R2 top semaphore
    {4'd3, 2'd0, 1'b0, 2'd0, 6'd63, 8'd0, 8'h06, 1'b0, 2'd0}, // R3 holder 3
    {4'd4, 2'd2, 1'b0, 2'd1, 6'd63, 8'd0, 8'h06, 1'b0, 2'd0}, // R4 holder 3
    {4'd2, 2'd2, 1'b0, 2'd0, 6'd0,  8'd0, 8'h01, 1'b0, 2'd0}, // R2 bottom semaphore
    {4'd3, 2'd3, 1'b0, 2'd0, 6'd0,  8'd0, 8'h04, 1'b0, 2'd0}, // R3 holder 2
    {4'd5, 2'd2, 1'b1, 2'd0, 6'd0,  8'd1, 8'h00, 1'b0, 2'd0}, // R5 release via direct
    {4'd2, 2'd3, 1'b0, 2'd0, 6'd0,  8'd0, 8'h01, 1'b0, 2'd0}, // R2 re-acquire
    {4'd1, 2'd1, 1'b0, 2'd3, 6'd0,  8'd0, 8'h00, 1'b0, 2'd0}, // R1 reserved read
    {4'd1, 2'd1, 1'b1, 2'd3, 6'd0,  8'd1, 8'h00, 1'b0, 2'd0}, // R1 reserved write
    {4'd1, 2'd1, 1'b0, 2'd1, 6'd0,  8'd0, 8'h06, 1'b0, 2'd0}  // R1 semaphore 0 untouched
  };

  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0]   rd;
    logic          rdy, ev;
    logic [1:0]    code;
    logic [SW-1:0] es;
    string         tg;

    idle_all();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // reset state: R9
    @(negedge clk);
    chk("R9 reset err_valid", 32'(err_valid), 32'h0);
    chk("R9 reset ready", 32'(ready), 32'hF);
    for (int s = 0; s < NS; s++) begin
      run1(s % NC, 1'b0, KIND_QUERY, s, 0, rd, rdy, ev, code, es);
      chk($sformatf("R9 reset free sem %0d", s), rd, 32'h1);
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = TBL[i];
      tg = $sformatf("R%0d vec %0d", v[33:30], i);
      run1(int'(v[29:28]), v[27], v[26:25], int'(v[24:19]), 32'(v[18:11]),
           rd, rdy, ev, code, es);
      chk({tg, " ready"}, 32'(rdy), 32'h1);
      chk({tg, " rdata"}, rd, 32'(v[10:3]));
      chk({tg, " err_valid"}, 32'(ev), 32'(v[2]));
      if (v[2]) begin
        chk({tg, " err_code"}, 32'(code), 32'(v[1:0]));
        chk({tg, " err_sem"}, 32'(es), 32'(v[24:19]));
      end
    end

    // R10: two cores on one semaphore, lowest wins, the other waits
    @(negedge clk);
    idle_all();
    drive(1, 1'b0, KIND_DIRECT, 10, 0);
    drive(2, 1'b0, KIND_DIRECT, 10, 0);
    #1;
    chk("R10 core1 ready", 32'(ready[1]), 32'h1);
    chk("R10 core1 grant", rdata[1*DW +: DW], 32'h1);
    chk("R10 core2 stalled", 32'(ready[2]), 32'h0);
    @(posedge clk);
    #1 req[1] = 1'b0;
    @(negedge clk);
    #1;
    chk("R10 core2 served", 32'(ready[2]), 32'h1);
    chk("R10 core2 sees holder 1", rdata[2*DW +: DW], 32'h2);
    @(posedge clk);
    #1 idle_all();

    // R10: distinct semaphores served together
    @(negedge clk);
    drive(0, 1'b0, KIND_DIRECT, 20, 0);
    drive(3, 1'b0, KIND_DIRECT, 21, 0);
    #1;
    chk("R10 parallel ready", 32'({ready[3], ready[0]}), 32'h3);
    chk("R10 parallel grant core0", rdata[0 +: DW], 32'h1);
    chk("R10 parallel grant core3", rdata[3*DW +: DW], 32'h1);
    @(posedge clk);
    #1 idle_all();
    @(negedge clk);
    chk("R11 no strobe on grants", 32'(err_valid), 32'h0);
    run1(1, 1'b0, KIND_QUERY, 20, 0, rd, rdy, ev, code, es);
    chk("R10 sem 20 holder 0", rd, 32'h0);
    run1(1, 1'b0, KIND_QUERY, 21, 0, rd, rdy, ev, code, es);
    chk("R10 sem 21 holder 3", rd, 32'h6);

    // R8: error strobe lasts one cycle
    run1(1, 1'b1, KIND_QUERY, 63, 1, rd, rdy, ev, code, es);
    chk("R8 strobe high", 32'(ev), 32'h1);
    chk("R8 code illegal", 32'(code), 32'h1);
    chk("R8 sem 63", 32'(es), 32'd63);
    @(negedge clk);
    chk("R8 strobe gone", 32'(err_valid[1]), 32'h0);

    // R9: soft reset wins the cycle and frees everything
    @(negedge clk);
    idle_all();
    drive(2, 1'b1, KIND_CTRL, 0, 1);
    drive(0, 1'b0, KIND_DIRECT, 30, 0);
    #1;
    chk("R9 ctrl served", 32'(ready[2]), 32'h1);
    chk("R9 other core stalled", 32'(ready[0]), 32'h0);
    @(posedge clk);
    #1 idle_all();
    foreach (TBL[i]) begin
    end
    for (int k = 0; k < 6; k++) begin
      int s;
      s = (k == 0) ? 63 : (k == 1) ? 0 : (k == 2) ? 10 : (k == 3) ? 20 : (k == 4) ? 21 : 30;
      run1(3, 1'b0, KIND_QUERY, s, 0, rd, rdy, ev, code, es);
      chk($sformatf("R9 soft reset freed sem %0d", s), rd, 32'h1);
    end

    // R9: hardware reset in mid-run
    run1(1, 1'b0, KIND_DIRECT, 7, 0, rd, rdy, ev, code, es);
    chk("R2 grant before hw reset", rd, 32'h1);
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 err lanes in reset", 32'(err_valid), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    run1(2, 1'b0, KIND_QUERY, 7, 0, rd, rdy, ev, code, es);
    chk("R9 hw reset freed sem 7", rd, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule